// File: doc/BRIEF.md
# Single-Precision Float Sign, Order and Classify Unit

This block handles the single-precision operations of a floating-point unit that need no arithmetic. It takes two 32-bit IEEE-754 operands, a 5-bit function code and a 3-bit sub-code. From these it produces a sign-injected value, the minimum or maximum of the two operands, a boolean comparison, a ten-way class mask, or a raw copy of the first operand's bits. Each operation applies its own rules for NaN inputs and its own rule for raising the invalid-operation flag.

The decode and datapath are fully combinational. The result, the invalid flag and a valid strobe are registered. An operation presented with `in_valid` high appears on the outputs after the next rising clock edge. When `in_valid` is low, the result register holds its value and the strobe drops.

Top module: `fpu_misc_unit`

## Requirements
- R1: Function 5'b00100 performs sign injection. Result bits 30:0 always equal op_a[30:0]. Result bit 31 depends on the sub-code: op_b[31] for 3'b000, ~op_b[31] for 3'b001, and op_a[31]^op_b[31] for 3'b010. NaN operands receive no special treatment, and the invalid flag stays 0.
- R2: Function 5'b00101 selects one operand. Sub-code 3'b000 returns the smaller operand and sub-code 3'b001 returns the larger one. For this selection, -0 (0x80000000) is treated as smaller than +0 (0x00000000).
- R3: In min/max, if exactly one operand is a NaN, the other operand is returned. If both are NaN, the result is 0x7FC00000. The invalid flag is raised only when an operand is a signaling NaN.
- R4: Function 5'b10100 compares op_a with op_b. Sub-code 3'b010 tests equal, 3'b001 tests less-than and 3'b000 tests less-or-equal. The answer is placed in bit 0 and bits 31:1 are zero. +0 and -0 compare equal.
- R5: Every compare returns 0 when either operand is a NaN, meaning exponent all ones with a nonzero mantissa.
- R6: The equal compare raises invalid only for a signaling NaN input. Less-than and less-or-equal raise invalid for any NaN input.
- R7: Function 5'b11100 with sub-code 3'b000 copies all 32 bits of op_a to the result and does not raise invalid.
- R8: Function 5'b11100 with sub-code 3'b001 writes a class mask with exactly one bit set and bits 31:10 clear. The bits are: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN, 9 quiet NaN. A NaN is quiet when mantissa bit 22 is set. Classification does not raise invalid.
- R9: Any function code or sub-code not listed above yields a zero result with the invalid flag set.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result and flag of that operation are presented in the same cycle.
- R11: A synchronous active-low reset clears `out_valid`, `out_result` and `out_invalid`, and takes priority over a concurrent input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| func | input | 5 | Function code |
| sub | input | 3 | Sub-function code |
| op_a | input | 32 | First operand, IEEE-754 single |
| op_b | input | 32 | Second operand, IEEE-754 single |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_result | output | 32 | Registered result |
| out_invalid | output | 1 | Registered invalid-operation flag |

## Verification
Every result and its invalid flag are due exactly one rising edge after the cycle in which `in_valid` was high, because a single register separates the operands from the outputs. The bench drives inputs on the falling edge and samples on the following falling edge, half a period after the capturing edge. It also runs two operations back to back and checks each one on its own due cycle. A separate check confirms that the strobe drops in the idle cycle after them. The reset case is sampled one edge after reset is asserted, with a request present at that same time.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int FP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int MAG_W = FP_W - 1;
    localparam int CLS_W = 10;

    typedef logic [4:0] func_t;
    typedef logic [2:0] sub_t;

    localparam func_t FN_SGNJ   = 5'b00100;
    localparam func_t FN_MINMAX = 5'b00101;
    localparam func_t FN_CMP    = 5'b10100;
    localparam func_t FN_MOVE   = 5'b11100;

    localparam logic [FP_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic zero;
        logic snan;
        logic qnan;
    } nanz_t;

    typedef struct packed {
        logic            valid;
        logic [FP_W-1:0] result;
        logic            invalid;
    } out_t;
endpackage

// File: rtl/fpm_flags.sv
module fpm_flags #(
    parameter int EW = fpm_pkg::EXP_W,
    parameter int MW = fpm_pkg::MAN_W
) (
    input  logic [EW+MW-1:0] mag,
    output fpm_pkg::nanz_t   fl
);
    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;
    logic          exp_max;

    assign exp_f   = mag[EW+MW-1:MW];
    assign man_f   = mag[MW-1:0];
    assign exp_max = &exp_f;

    always_comb begin
        fl.zero = (mag == '0);
        fl.snan = exp_max && (man_f != '0) && !man_f[MW-1];
        fl.qnan = exp_max && man_f[MW-1];
    end
endmodule

// File: rtl/fpm_class_mask.sv
module fpm_class_mask #(
    parameter int EW = fpm_pkg::EXP_W,
    parameter int MW = fpm_pkg::MAN_W,
    parameter int CW = fpm_pkg::CLS_W
) (
    input  logic [EW+MW:0] val,
    output logic [CW-1:0]  mask
);
    logic          sgn;
    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;
    logic          exp_max, exp_min, man_nil;

    assign sgn     = val[EW+MW];
    assign exp_f   = val[EW+MW-1:MW];
    assign man_f   = val[MW-1:0];
    assign exp_max = &exp_f;
    assign exp_min = (exp_f == '0);
    assign man_nil = (man_f == '0);

    always_comb begin
        mask = '0;
        if (exp_max && !man_nil)
            mask[man_f[MW-1] ? 9 : 8] = 1'b1;
        else if (exp_max)
            mask[sgn ? 0 : 7] = 1'b1;
        else if (exp_min && man_nil)
            mask[sgn ? 3 : 4] = 1'b1;
        else if (exp_min)
            mask[sgn ? 2 : 5] = 1'b1;
        else
            mask[sgn ? 1 : 6] = 1'b1;
    end
endmodule

// File: rtl/fpm_order.sv
module fpm_order #(
    parameter int W = fpm_pkg::FP_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_zero,
    input  logic         b_zero,
    output logic         eq,
    output logic         lt,
    output logic         lt_tot
);
    logic mag_lt, mag_gt, both_zero;

    assign mag_lt    = a[W-2:0] < b[W-2:0];
    assign mag_gt    = a[W-2:0] > b[W-2:0];
    assign both_zero = a_zero && b_zero;

    always_comb begin
        if (a[W-1] != b[W-1])
            lt_tot = a[W-1];
        else if (!a[W-1])
            lt_tot = mag_lt;
        else
            lt_tot = mag_gt;
        eq = both_zero || (a == b);
        lt = lt_tot && !both_zero;
    end
endmodule

// File: rtl/fpu_misc_unit.sv
module fpu_misc_unit
    import fpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [4:0]  func,
    input  logic [2:0]  sub,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic        out_invalid
);
    logic [MAG_W-1:0] mag [2];
    nanz_t            fl  [2];
    logic [CLS_W-1:0] cls_mask;
    logic             ord_eq, ord_lt, ord_lt_tot;
    logic             a_nan, b_nan, any_nan, any_snan;
    out_t             st_d, st_q;

    assign mag[0] = op_a[MAG_W-1:0];
    assign mag[1] = op_b[MAG_W-1:0];

    for (genvar gi = 0; gi < 2; gi++) begin : g_flags
        fpm_flags #(.EW(EXP_W), .MW(MAN_W)) u_flags (
            .mag (mag[gi]),
            .fl  (fl[gi])
        );
    end

    fpm_class_mask #(.EW(EXP_W), .MW(MAN_W), .CW(CLS_W)) u_mask (
        .val  (op_a),
        .mask (cls_mask)
    );

    fpm_order #(.W(FP_W)) u_order (
        .a      (op_a),
        .b      (op_b),
        .a_zero (fl[0].zero),
        .b_zero (fl[1].zero),
        .eq     (ord_eq),
        .lt     (ord_lt),
        .lt_tot (ord_lt_tot)
    );

    assign a_nan    = fl[0].snan || fl[0].qnan;
    assign b_nan    = fl[1].snan || fl[1].qnan;
    assign any_nan  = a_nan || b_nan;
    assign any_snan = fl[0].snan || fl[1].snan;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result  = '0;
            st_d.invalid = 1'b0;
            case (func)
                FN_SGNJ: begin
                    case (sub)
                        3'b000:  st_d.result = {op_b[FP_W-1], op_a[MAG_W-1:0]};
                        3'b001:  st_d.result = {~op_b[FP_W-1], op_a[MAG_W-1:0]};
                        3'b010:  st_d.result = {op_a[FP_W-1] ^ op_b[FP_W-1],
                                                op_a[MAG_W-1:0]};
                        default: st_d.invalid = 1'b1;
                    endcase
                end
                FN_MINMAX: begin
                    if (sub == 3'b000 || sub == 3'b001) begin
                        st_d.invalid = any_snan;
                        if (a_nan && b_nan)
                            st_d.result = CANON_NAN;
                        else if (a_nan)
                            st_d.result = op_b;
                        else if (b_nan)
                            st_d.result = op_a;
                        else if (ord_lt_tot == (sub == 3'b000))
                            st_d.result = op_a;
                        else
                            st_d.result = op_b;
                    end else begin
                        st_d.invalid = 1'b1;
                    end
                end
                FN_CMP: begin
                    case (sub)
                        3'b010: begin
                            st_d.result[0] = !any_nan && ord_eq;
                            st_d.invalid   = any_snan;
                        end
                        3'b001: begin
                            st_d.result[0] = !any_nan && ord_lt;
                            st_d.invalid   = any_nan;
                        end
                        3'b000: begin
                            st_d.result[0] = !any_nan && (ord_lt || ord_eq);
                            st_d.invalid   = any_nan;
                        end
                        default: st_d.invalid = 1'b1;
                    endcase
                end
                FN_MOVE: begin
                    case (sub)
                        3'b000:  st_d.result = op_a;
                        3'b001:  st_d.result = {{(FP_W-CLS_W){1'b0}}, cls_mask};
                        default: st_d.invalid = 1'b1;
                    endcase
                end
                default: st_d.invalid = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_invalid = st_q.invalid;
endmodule

// File: rtl/fpm_misc_chk.sv
module fpm_misc_chk
    import fpm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  func,
    input logic [2:0]  sub,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        out_valid,
    input logic [31:0] out_result,
    input logic        out_invalid
);
    logic a_is_nan, b_is_nan, legal;

    assign a_is_nan = (op_a[30:23] == 8'hFF) && (op_a[22:0] != '0);
    assign b_is_nan = (op_b[30:23] == 8'hFF) && (op_b[22:0] != '0);
    assign legal = (func == FN_SGNJ   && sub <= 3'd2) ||
                   (func == FN_MINMAX && sub <= 3'd1) ||
                   (func == FN_CMP    && sub <= 3'd2) ||
                   (func == FN_MOVE   && sub <= 3'd1);

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_sgnj_body_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_SGNJ && sub <= 3'd2
        |=> out_result[30:0] == $past(op_a[30:0]) && !out_invalid);
    assert_sgnj_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_SGNJ && sub == 3'd0
        |=> out_result[31] == $past(op_b[31]));
    assert_both_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_MINMAX && sub <= 3'd1 && a_is_nan && b_is_nan
        |=> out_result == 32'h7FC00000);
    assert_cmp_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_CMP && sub <= 3'd2
        |=> out_result[31:1] == '0);
    assert_cmp_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_CMP && sub <= 3'd2 && (a_is_nan || b_is_nan)
        |=> out_result == '0);
    assert_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_MOVE && sub == 3'd0
        |=> out_result == $past(op_a) && !out_invalid);
    assert_class_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && func == FN_MOVE && sub == 3'd1
        |=> $countones(out_result) == 1 && out_result[31:10] == '0 && !out_invalid);
    assert_unsupported_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !legal |=> out_result == '0 && out_invalid);
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !out_valid && out_result == '0 && !out_invalid);
endmodule

bind fpu_misc_unit fpm_misc_chk u_fpm_misc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .func        (func),
    .sub         (sub),
    .op_a        (op_a),
    .op_b        (op_b),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid)
);

// File: tb/tb_fpu_misc_unit.sv
module tb_fpu_misc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  func = '0;
    logic [2:0]  sub = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fpu_misc_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func), .sub(sub),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    // {tag, func, sub, op_a, op_b, expected result, expected invalid}
    localparam int NV = 44;
    localparam logic [108:0] VEC [NV] = '{
        {4'd1, 5'b00100, 3'b000, 32'h3F800000, 32'hC0000000, 32'hBF800000, 1'b0}, // R1
        {4'd1, 5'b00100, 3'b001, 32'h3F800000, 32'hC0000000, 32'h3F800000, 1'b0}, // R1
        {4'd1, 5'b00100, 3'b010, 32'hBF800000, 32'hC0000000, 32'h3F800000, 1'b0}, // R1
        {4'd1, 5'b00100, 3'b001, 32'h7FC00000, 32'h00000000, 32'hFFC00000, 1'b0}, // R1
        {4'd2, 5'b00101, 3'b000, 32'h3F800000, 32'hC0000000, 32'hC0000000, 1'b0}, // R2
        {4'd2, 5'b00101, 3'b001, 32'h3F800000, 32'hC0000000, 32'h3F800000, 1'b0}, // R2
        {4'd2, 5'b00101, 3'b000, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0}, // R2
        {4'd2, 5'b00101, 3'b001, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0}, // R2
        {4'd2, 5'b00101, 3'b000, 32'hC0000000, 32'hBF800000, 32'hC0000000, 1'b0}, // R2
        {4'd3, 5'b00101, 3'b001, 32'h7FC00000, 32'h3FC00000, 32'h3FC00000, 1'b0}, // R3
        {4'd3, 5'b00101, 3'b000, 32'h7F800001, 32'hBF800000, 32'hBF800000, 1'b1}, // R3
        {4'd3, 5'b00101, 3'b001, 32'h7FC00000, 32'h7F800001, 32'h7FC00000, 1'b1}, // R3
        {4'd3, 5'b00101, 3'b000, 32'h7FC00000, 32'hFFC00000, 32'h7FC00000, 1'b0}, // R3
        {4'd4, 5'b10100, 3'b010, 32'h3F800000, 32'h3F800000, 32'h00000001, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b010, 32'h00000000, 32'h80000000, 32'h00000001, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b001, 32'hC0000000, 32'hBF800000, 32'h00000001, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b001, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b000, 32'h3F800000, 32'h3F800000, 32'h00000001, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b000, 32'h40000000, 32'h3F800000, 32'h00000000, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b001, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0}, // R4
        {4'd4, 5'b10100, 3'b000, 32'hFF800000, 32'h7F800000, 32'h00000001, 1'b0}, // R4
        {4'd5, 5'b10100, 3'b010, 32'h7FC00000, 32'h7FC00000, 32'h00000000, 1'b0}, // R5
        {4'd6, 5'b10100, 3'b010, 32'h3F800000, 32'h7F800001, 32'h00000000, 1'b1}, // R6
        {4'd6, 5'b10100, 3'b001, 32'h7FC00000, 32'h3F800000, 32'h00000000, 1'b1}, // R6
        {4'd6, 5'b10100, 3'b000, 32'h3F800000, 32'hFFC00000, 32'h00000000, 1'b1}, // R6
        {4'd7, 5'b11100, 3'b000, 32'hDEADBEEF, 32'h12345678, 32'hDEADBEEF, 1'b0}, // R7
        {4'd7, 5'b11100, 3'b000, 32'h7F800001, 32'h00000000, 32'h7F800001, 1'b0}, // R7
        {4'd8, 5'b11100, 3'b001, 32'hFF800000, 32'h00000000, 32'h00000001, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'hBF800000, 32'h00000000, 32'h00000002, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h80000001, 32'h00000000, 32'h00000004, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h80000000, 32'h00000000, 32'h00000008, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h00000000, 32'h00000000, 32'h00000010, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h00000001, 32'h00000000, 32'h00000020, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h3F800000, 32'h00000000, 32'h00000040, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h7F800000, 32'h00000000, 32'h00000080, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h7F800001, 32'h00000000, 32'h00000100, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'h7FC00000, 32'h00000000, 32'h00000200, 1'b0}, // R8
        {4'd8, 5'b11100, 3'b001, 32'hFFFFFFFF, 32'h00000000, 32'h00000200, 1'b0}, // R8
        {4'd9, 5'b00000, 3'b000, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b1}, // R9
        {4'd9, 5'b00100, 3'b011, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b1}, // R9
        {4'd9, 5'b00101, 3'b010, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b1}, // R9
        {4'd9, 5'b10100, 3'b011, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b1}, // R9
        {4'd9, 5'b11100, 3'b010, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b1}, // R9
        {4'd9, 5'b11111, 3'b000, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b1}  // R9
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] f, input logic [2:0] s,
                         input logic [31:0] a, input logic [31:0] b);
        func = f; sub = s; op_a = a; op_b = b; in_valid = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R11: state while held in reset
        repeat (3) @(negedge clk);
        check("R11", "valid in reset", {31'b0, out_valid}, 32'h0);
        check("R11", "result in reset", out_result, 32'h0);
        check("R11", "invalid in reset", {31'b0, out_invalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][108:105]);
            drive(VEC[i][104:100], VEC[i][99:97], VEC[i][96:65], VEC[i][64:33]);
            @(negedge clk);
            in_valid = 1'b0;
            check(tag, $sformatf("vec %0d result", i), out_result, VEC[i][32:1]);
            check(tag, $sformatf("vec %0d invalid", i),
                  {31'b0, out_invalid}, {31'b0, VEC[i][0]});
            check("R10", $sformatf("vec %0d valid", i), {31'b0, out_valid}, 32'h1);
        end

        // R10: back-to-back requests, each due one edge later, then idle
        drive(5'b00100, 3'b000, 32'h40000000, 32'h80000000);
        @(negedge clk);
        check("R10", "b2b first result", out_result, 32'hC0000000);
        check("R10", "b2b first valid", {31'b0, out_valid}, 32'h1);
        drive(5'b11100, 3'b000, 32'hA5A5A5A5, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", "b2b second result", out_result, 32'hA5A5A5A5);
        check("R10", "b2b second valid", {31'b0, out_valid}, 32'h1);
        @(negedge clk);
        check("R10", "idle valid low", {31'b0, out_valid}, 32'h0);

        // R11: reset wins over a concurrent unsupported request
        drive(5'b00000, 3'b111, 32'h3F800000, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11", "valid after reset", {31'b0, out_valid}, 32'h0);
        check("R11", "result after reset", out_result, 32'h0);
        check("R11", "invalid after reset", {31'b0, out_invalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule